// File: doc/BRIEF.md
# Head Step and Restore Sequencer

This block moves the read/write head of a drive that is positioned by step pulses. A seek command carries a target track. The sequencer compares the target with the track it holds as current and sets the direction line. It then sends exactly as many step pulses as the two tracks differ. Pulse width and the gap between pulses come from inputs. After the last pulse the direction line is held for a margin. The sequencer then waits for the drive's seek-complete line and counts a head-settle time before it reports done.

Two restore modes bring the head back to the outermost track. Stepped restore sends outward pulses one at a time. After each pulse it waits for seek-complete to fall and rise again, then samples the track-zero input. Pulsed restore sends a single return-to-zero pulse as wide as a step pulse. If track zero is still low once seek-complete returns, it falls back to stepped restore. A stepped restore that runs out of its step budget ends with an error.

From the current track the block also derives two enables for the write path: precompensation and reduced write current. Each is a registered comparison against its own threshold.

FSM states:

| State | Meaning |
| --- | --- |
| IDLE | Waiting for a command. |
| CHECK | Verifies that seek-complete is high before any motion. |
| SETUP | Direction setup margin. |
| PULSE | Step pulse high. |
| RZP | Return-to-zero pulse high. |
| GAP | Low time between pulses. |
| R_LOW | Restore waits for seek-complete to go low. |
| R_HIGH | Restore waits for seek-complete to go high, then samples track zero. |
| HOLD | Direction hold margin. |
| WAIT_SC | Waits for seek-complete after a seek. |
| SETTLE | Head settle count. |
| FIN_OK | One-cycle done. |
| FIN_ERR | One-cycle error. |

FSM transitions:

| From | Condition | To |
| --- | --- | --- |
| IDLE | command strobe | CHECK |
| CHECK | seek-complete low | FIN_ERR |
| CHECK | zero-distance seek | SETTLE |
| CHECK | otherwise | SETUP |
| SETUP | margin over, pulsed restore | RZP |
| SETUP | margin over, other modes | PULSE |
| PULSE | seek pulses remain | GAP |
| PULSE | seek done | HOLD |
| PULSE | restore modes | R_LOW |
| RZP | width over | R_LOW |
| GAP | gap over | PULSE |
| R_LOW | seek-complete low | R_HIGH |
| R_HIGH | seek-complete high and track zero high | HOLD |
| R_HIGH | seek-complete high, track zero low, step budget used up | FIN_ERR |
| R_HIGH | seek-complete high, track zero low, otherwise (pulsed restore falls back to stepped here) | GAP |
| HOLD | margin over | WAIT_SC |
| WAIT_SC | seek-complete high | SETTLE |
| SETTLE | count over | FIN_OK |
| FIN_OK | always | IDLE |
| FIN_ERR | always | IDLE |

Top module: `head_seek_seq`

## Requirements
- R1: A command is taken only in the idle state, on a one-cycle `cmd_go`. `cmd_op` encodes 0 as seek, 1 as stepped restore, 2 as pulsed restore, and 3 as seek. A `cmd_go` while `busy_o` is high is ignored: no extra pulses follow, and the track reached is that of the first command.
- R2: A seek issues exactly |target − current| step pulses. `dir_o` is 1 when the target is higher, and each pulse moves the track by one in that direction. At done, `cur_trk_o` equals the target.
- R3: Every step pulse is high for exactly max(`step_w`,1) cycles. Between two pulses of a seek, `step_o` is low for exactly max(`step_gap`,1) cycles.
- R4: `dir_o` settles at least 4 cycles before the first step pulse rises. It does not change from then until done, which comes at least 4 cycles after the last pulse falls.
- R5: If seek-complete is low when the command is checked, the sequencer reports `err_o`. It sends no pulse and leaves the track unchanged.
- R6: After the hold margin a seek waits for seek-complete high. It then counts max(`settle_cnt`,1) cycles before a one-cycle `done_o`, so done comes at least 4+max(`settle_cnt`,1) cycles after the last pulse falls.
- R7: A seek to the current track sends no pulse and still ends with `done_o`.
- R8: A stepped restore drives `dir_o`=0 on every pulse. After each pulse it waits for seek-complete to fall and rise before it samples track zero, so pulses are spaced at least max(`step_gap`,1) low cycles apart. When track zero is seen, `cur_trk_o` becomes 0 and done follows.
- R9: A stepped restore that has sent max(`rst_max`,1) pulses without seeing track zero ends with `err_o`. Each of those pulses lowers `cur_trk_o` by one, saturating at 0.
- R10: A pulsed restore sends one `rtz_o` pulse of max(`step_w`,1) cycles and never overlaps it with a step pulse. If track zero is high once seek-complete has returned, it finishes with no step pulse. Otherwise it continues as a stepped restore.
- R11: `pcen_o` = (`cur_trk_o` ≥ `pcomp_trk`) and `rwc_o` = (`cur_trk_o` ≥ `rwc_trk`), each registered one cycle. While idle with stable thresholds, neither changes.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_go | input | 1 | Command strobe |
| cmd_op | input | 2 | Command operation code |
| cmd_trk | input | TRK_W | Target track for a seek |
| step_w | input | TIM_W | Step and return-to-zero pulse width |
| step_gap | input | TIM_W | Low time between pulses |
| settle_cnt | input | TIM_W | Head settle cycles |
| rst_max | input | TRK_W | Restore step budget |
| pcomp_trk | input | TRK_W | Precompensation threshold track |
| rwc_trk | input | TRK_W | Reduced write current threshold track |
| sk_cmp_i | input | 1 | Seek complete from the drive |
| trk0_i | input | 1 | Track zero from the drive |
| step_o | output | 1 | Step pulse, drive moves on its rise |
| dir_o | output | 1 | Direction, 1 toward higher tracks |
| rtz_o | output | 1 | Return-to-zero pulse |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle success |
| err_o | output | 1 | One-cycle failure |
| cur_trk_o | output | TRK_W | Current track |
| pcen_o | output | 1 | Precompensation enable |
| rwc_o | output | 1 | Reduced write current enable |

## Verification
The assertions take the configuration inputs and thresholds to be steady while a command runs. They also assume the drive holds track zero steady while the sequencer is stepping. The bench holds every setting fixed from the command strobe until done, and changes thresholds only while the block is idle. Its drive model lowers seek-complete on each pulse edge for three cycles and derives track zero from a head position it moves on each step rise. The stimulus therefore never shows the sequencer a track-zero change in the middle of a pulse.

// File: rtl/hss_pkg.sv
package hss_pkg;

    typedef enum logic [1:0] {
        OP_SEEK     = 2'd0,
        OP_RST_STEP = 2'd1,
        OP_RST_RTZ  = 2'd2
    } hss_op_t;

    typedef enum logic [3:0] {
        S_IDLE, S_CHECK, S_SETUP, S_PULSE, S_RZP, S_GAP, S_R_LOW,
        S_R_HIGH, S_HOLD, S_WAIT_SC, S_SETTLE, S_FIN_OK, S_FIN_ERR
    } hss_state_t;

endpackage

// File: rtl/hss_timer.sv
module hss_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (ld)           cnt_q <= val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/hss_trk_cmp.sv
module hss_trk_cmp #(
    parameter int TRK_W = 16,
    parameter int N     = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [TRK_W-1:0]          cur,
    input  logic [N-1:0][TRK_W-1:0]   thr,
    output logic [N-1:0]              ge
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        always_ff @(posedge clk) begin
            if (!rst_n) ge[i] <= 1'b0;
            else        ge[i] <= (cur >= thr[i]);
        end
    end
endmodule

// File: rtl/head_seek_seq.sv
module head_seek_seq
    import hss_pkg::*;
#(
    parameter int TRK_W  = 16,
    parameter int TIM_W  = 8,
    parameter int MARGIN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_go,
    input  logic [1:0]       cmd_op,
    input  logic [TRK_W-1:0] cmd_trk,
    input  logic [TIM_W-1:0] step_w,
    input  logic [TIM_W-1:0] step_gap,
    input  logic [TIM_W-1:0] settle_cnt,
    input  logic [TRK_W-1:0] rst_max,
    input  logic [TRK_W-1:0] pcomp_trk,
    input  logic [TRK_W-1:0] rwc_trk,
    input  logic             sk_cmp_i,
    input  logic             trk0_i,
    output logic             step_o,
    output logic             dir_o,
    output logic             rtz_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o,
    output logic [TRK_W-1:0] cur_trk_o,
    output logic             pcen_o,
    output logic             rwc_o
);
    localparam logic [TIM_W-1:0] MRG_LD  = TIM_W'(MARGIN - 1);
    localparam logic [TRK_W-1:0] TRK_ONE = TRK_W'(1);

    hss_state_t       state_q, state_d;
    hss_op_t          mode_q, op_in;
    logic             dir_q;
    logic [TRK_W-1:0] cur_q, tgt_q, rem_q, nstep_q, lim;
    logic             tmr_ld, tmr_zero;
    logic [TIM_W-1:0] tmr_val;
    logic [1:0]       ge;

    function automatic logic [TIM_W-1:0] len_m1(input logic [TIM_W-1:0] n);
        return (n == '0) ? '0 : n - 1'b1;
    endfunction

    assign op_in = (cmd_op == 2'd3) ? OP_SEEK : hss_op_t'(cmd_op);
    assign lim   = (rst_max == '0) ? TRK_ONE : rst_max;

    hss_timer #(.W(TIM_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .ld(tmr_ld), .val(tmr_val), .zero(tmr_zero)
    );

    hss_trk_cmp #(.TRK_W(TRK_W), .N(2)) u_cmp (
        .clk(clk), .rst_n(rst_n), .cur(cur_q), .thr({rwc_trk, pcomp_trk}), .ge(ge)
    );

    // next state and timer loads
    always_comb begin
        state_d = state_q;
        tmr_ld  = 1'b0;
        tmr_val = '0;
        unique case (state_q)
            S_IDLE:    if (cmd_go) state_d = S_CHECK;
            S_CHECK: begin
                tmr_ld = 1'b1;
                if (!sk_cmp_i) begin
                    state_d = S_FIN_ERR;
                end else if (mode_q == OP_SEEK && tgt_q == cur_q) begin
                    state_d = S_SETTLE;
                    tmr_val = len_m1(settle_cnt);
                end else begin
                    state_d = S_SETUP;
                    tmr_val = MRG_LD;
                end
            end
            S_SETUP: if (tmr_zero) begin
                state_d = (mode_q == OP_RST_RTZ) ? S_RZP : S_PULSE;
                tmr_ld  = 1'b1;
                tmr_val = len_m1(step_w);
            end
            S_PULSE: if (tmr_zero) begin
                if (mode_q != OP_SEEK) begin
                    state_d = S_R_LOW;
                end else if (rem_q == '0) begin
                    state_d = S_HOLD;
                    tmr_ld  = 1'b1;
                    tmr_val = MRG_LD;
                end else begin
                    state_d = S_GAP;
                    tmr_ld  = 1'b1;
                    tmr_val = len_m1(step_gap);
                end
            end
            S_RZP:   if (tmr_zero) state_d = S_R_LOW;
            S_GAP: if (tmr_zero) begin
                state_d = S_PULSE;
                tmr_ld  = 1'b1;
                tmr_val = len_m1(step_w);
            end
            S_R_LOW: if (!sk_cmp_i) state_d = S_R_HIGH;
            S_R_HIGH: if (sk_cmp_i) begin
                if (trk0_i) begin
                    state_d = S_HOLD;
                    tmr_ld  = 1'b1;
                    tmr_val = MRG_LD;
                end else if (mode_q == OP_RST_STEP && nstep_q >= lim) begin
                    state_d = S_FIN_ERR;
                end else begin
                    state_d = S_GAP;
                    tmr_ld  = 1'b1;
                    tmr_val = len_m1(step_gap);
                end
            end
            S_HOLD:  if (tmr_zero) state_d = S_WAIT_SC;
            S_WAIT_SC: if (sk_cmp_i) begin
                state_d = S_SETTLE;
                tmr_ld  = 1'b1;
                tmr_val = len_m1(settle_cnt);
            end
            S_SETTLE:  if (tmr_zero) state_d = S_FIN_OK;
            S_FIN_OK:  state_d = S_IDLE;
            S_FIN_ERR: state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // command, direction and track registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= OP_SEEK;
            dir_q   <= 1'b0;
            cur_q   <= '0;
            tgt_q   <= '0;
            rem_q   <= '0;
            nstep_q <= '0;
        end else begin
            if (state_q == S_IDLE && cmd_go) begin
                mode_q  <= op_in;
                tgt_q   <= cmd_trk;
                nstep_q <= '0;
                dir_q   <= (op_in == OP_SEEK) && (cmd_trk > cur_q);
                rem_q   <= (cmd_trk > cur_q) ? cmd_trk - cur_q : cur_q - cmd_trk;
            end
            if (state_d == S_PULSE && state_q != S_PULSE) begin
                if (mode_q == OP_SEEK) begin
                    rem_q <= rem_q - 1'b1;
                    cur_q <= dir_q ? cur_q + 1'b1 : cur_q - 1'b1;
                end else begin
                    nstep_q <= nstep_q + 1'b1;
                    cur_q   <= (cur_q == '0) ? '0 : cur_q - 1'b1;
                end
            end
            if (state_q == S_R_HIGH && sk_cmp_i) begin
                if (trk0_i)                        cur_q  <= '0;
                else if (mode_q == OP_RST_RTZ)     mode_q <= OP_RST_STEP;
            end
        end
    end

    // outputs
    always_comb begin
        step_o    = (state_q == S_PULSE);
        rtz_o     = (state_q == S_RZP);
        busy_o    = (state_q != S_IDLE);
        done_o    = (state_q == S_FIN_OK);
        err_o     = (state_q == S_FIN_ERR);
        dir_o     = dir_q;
        cur_trk_o = cur_q;
        pcen_o    = ge[0];
        rwc_o     = ge[1];
    end

    // checks
    logic       moving;
    logic [1:0] age_q;
    assign moving = state_q inside {S_SETUP, S_PULSE, S_RZP, S_GAP, S_R_LOW, S_R_HIGH, S_HOLD};

    always_ff @(posedge clk) begin
        if (!rst_n)             age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 1'b1;
    end

    a_r4_dir_stable: assert property (@(posedge clk) disable iff (!rst_n)
        moving && $past(moving) |-> $stable(dir_o));

    a_r5_sc_gate: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_CHECK && !sk_cmp_i |=> err_o && !step_o);

    a_r8_restore_outward: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q != OP_SEEK && step_o |-> !dir_o);

    a_r9_step_budget: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(step_o) && mode_q == OP_RST_STEP |-> nstep_q <= lim);

    a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_o && rtz_o));

    a_r1_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && cmd_go |=> $stable(tgt_q));

    a_r11_idle_enables: assert property (@(posedge clk) disable iff (!rst_n)
        age_q == 2'd3 && $past(!busy_o, 2) && $past(!busy_o)
        && $past($stable(pcomp_trk)) && $past($stable(rwc_trk))
        |-> $stable({pcen_o, rwc_o}));
endmodule

// File: tb/tb_head_seek_seq.sv
module tb_head_seek_seq;
    localparam int TRK_W = 16;
    localparam int TIM_W = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_go = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [TRK_W-1:0] cmd_trk = '0, rst_max = 16'd100, pcomp_trk = 16'd10, rwc_trk = 16'd20;
    logic [TIM_W-1:0] step_w = 8'd1, step_gap = 8'd1, settle_cnt = 8'd1;
    logic sk_cmp_i, trk0_i;
    logic step_o, dir_o, rtz_o, busy_o, done_o, err_o, pcen_o, rwc_o;
    logic [TRK_W-1:0] cur_trk_o;

    head_seek_seq #(.TRK_W(TRK_W), .TIM_W(TIM_W)) dut (.*);

    always #10 clk = ~clk;

    int cyc = 0, nchk = 0, nerr = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // drive model
    int pos = 0, sc_cnt = 0;
    logic sc_force_low = 1'b0, rtz_fail = 1'b0, pstep = 1'b0, prtz = 1'b0;
    always @(posedge clk) begin
        pstep <= step_o;
        prtz  <= rtz_o;
        if (step_o && !pstep) begin
            pos    <= dir_o ? pos + 1 : (pos > 0 ? pos - 1 : 0);
            sc_cnt <= 3;
        end else if (rtz_o && !prtz) begin
            if (!rtz_fail) pos <= 0;
            sc_cnt <= 3;
        end else if (sc_cnt > 0) sc_cnt <= sc_cnt - 1;
    end
    assign sk_cmp_i = !sc_force_low && (sc_cnt == 0);
    assign trk0_i   = (pos == 0);

    // monitor
    int n_step, n_rtz, n_up, bad_w, bad_rw, gap_min, gap_max, run, rrun, lowrun;
    int first_rise, last_fall, last_dirchg = 0, setup_m, late_dir, exp_w;
    logic ps = 1'b0, pr = 1'b0, pd = 1'b0;
    always @(negedge clk) begin
        if (dir_o != pd) begin
            last_dirchg = cyc;
            if (n_step > 0) late_dir++;
        end
        if (step_o) begin
            if (!ps) begin
                n_step++;
                if (dir_o) n_up++;
                if (n_step == 1) setup_m = cyc - last_dirchg;
                else begin
                    if (lowrun < gap_min) gap_min = lowrun;
                    if (lowrun > gap_max) gap_max = lowrun;
                end
                run = 1;
            end else run++;
        end else if (ps) begin
            if (run != exp_w) bad_w++;
            last_fall = cyc;
            lowrun = 1;
        end else lowrun++;
        if (rtz_o) rrun = pr ? rrun + 1 : 1;
        else if (pr) begin
            n_rtz++;
            if (rrun != exp_w) bad_rw++;
        end
        ps = step_o; pr = rtz_o; pd = dir_o;
    end

    task automatic clr();
        n_step = 0; n_rtz = 0; n_up = 0; bad_w = 0; bad_rw = 0; late_dir = 0;
        gap_min = 1000000; gap_max = 0; run = 0; rrun = 0; lowrun = 0;
        setup_m = 1000000; last_fall = 0; first_rise = 0;
    endtask

    task automatic chk(input bit c, input string tag, input int act, input int exp);
        nchk++;
        if (!c) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int lenf(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int absd(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    int end_cyc;
    logic r_ok, r_er;

    task automatic do_cmd(input int op, input int tgt, input int w, input int g, input int s);
        int t;
        clr();
        step_w = TIM_W'(w); step_gap = TIM_W'(g); settle_cnt = TIM_W'(s);
        exp_w = lenf(w);
        cmd_op = 2'(op); cmd_trk = TRK_W'(tgt); cmd_go = 1'b1;
        @(negedge clk);
        cmd_go = 1'b0;
        t = 0;
        while (!(done_o || err_o) && t < 20000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 20000) chk(0, "R2 command timeout", t, 0);
        r_ok = done_o; r_er = err_o; end_cyc = cyc;
        @(negedge clk);
    endtask

    task automatic seek_checks(input int from, input int tgt, input int w, input int g, input int s);
        int d;
        d = absd(from, tgt);
        do_cmd(0, tgt, w, g, s);
        chk(r_ok, "R2 done", int'(r_ok), 1);
        chk(n_step == d, "R2 pulse count", n_step, d);
        chk(int'(cur_trk_o) == tgt, "R2 track", int'(cur_trk_o), tgt);
        chk(pos == tgt, "R2 head position", pos, tgt);
        chk(n_up == ((tgt > from) ? d : 0), "R2 direction", n_up, (tgt > from) ? d : 0);
        if (d > 0) begin
            chk(bad_w == 0, "R3 step width", bad_w, 0);
            chk(setup_m >= 4, "R4 direction setup", setup_m, 4);
            chk(late_dir == 0, "R4 direction hold", late_dir, 0);
            chk(end_cyc - last_fall >= 4 + lenf(s), "R6 settle", end_cyc - last_fall, 4 + lenf(s));
        end
        if (d > 1) chk(gap_min == lenf(g) && gap_max == lenf(g), "R3 spacing", gap_max, lenf(g));
        chk(pcen_o == (tgt >= int'(pcomp_trk)), "R11 pcen", int'(pcen_o), int'(tgt >= int'(pcomp_trk)));
        chk(rwc_o == (tgt >= int'(rwc_trk)), "R11 rwc", int'(rwc_o), int'(tgt >= int'(rwc_trk)));
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            nerr++; nchk++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        int cur, tg, w, g, s;
        void'($urandom(32'd1234));
        clr();
        exp_w = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !step_o && !rtz_o && !done_o && !err_o && cur_trk_o == '0,
            "R1 reset state", int'(busy_o), 0);

        // R7 zero-distance seek
        do_cmd(0, 0, 2, 2, 3);
        chk(r_ok && n_step == 0, "R7 zero distance", n_step, 0);

        // random seeks: R2 R3 R4 R6 R11
        cur = 0;
        for (int i = 0; i < 20; i++) begin
            tg = int'($urandom % 41);
            w  = int'($urandom % 4);
            g  = int'($urandom % 4);
            s  = int'($urandom % 6);
            seek_checks(cur, tg, w, g, s);
            cur = tg;
        end
        seek_checks(cur, cur + 1, 0, 0, 0);
        cur = cur + 1;

        // R5 seek complete low at start
        sc_force_low = 1'b1;
        do_cmd(0, cur + 5, 1, 1, 1);
        chk(r_er && n_step == 0, "R5 error without pulses", n_step, 0);
        chk(int'(cur_trk_o) == cur, "R5 track unchanged", int'(cur_trk_o), cur);
        sc_force_low = 1'b0;

        // R1 command during busy ignored, code 3 acts as seek
        clr();
        exp_w = 2; step_w = 8'd2; step_gap = 8'd2; settle_cnt = 8'd1;
        cmd_op = 2'd0; cmd_trk = TRK_W'(cur + 6); cmd_go = 1'b1;
        @(negedge clk);
        cmd_go = 1'b0;
        repeat (10) @(negedge clk);
        cmd_op = 2'd1; cmd_trk = '0; cmd_go = 1'b1;
        @(negedge clk);
        cmd_go = 1'b0;
        while (!done_o && !err_o) @(negedge clk);
        repeat (40) @(negedge clk);
        chk(n_step == 6, "R1 busy command ignored pulses", n_step, 6);
        chk(int'(cur_trk_o) == cur + 6 && !busy_o, "R1 busy command ignored track", int'(cur_trk_o), cur + 6);
        cur = cur + 6;
        do_cmd(3, 12, 1, 1, 1);
        chk(r_ok && cur_trk_o == 16'd12, "R1 code 3 seeks", int'(cur_trk_o), 12);

        // R8 stepped restore
        seek_checks(12, 30, 1, 2, 1);
        rst_max = 16'd100;
        do_cmd(1, 0, 2, 3, 2);
        chk(r_ok && n_step == 30, "R8 restore pulses", n_step, 30);
        chk(n_up == 0, "R8 outward direction", n_up, 0);
        chk(cur_trk_o == '0 && pos == 0, "R8 track zero", int'(cur_trk_o), 0);
        chk(gap_min >= 3 && bad_w == 0, "R8 spacing", gap_min, 3);

        // R9 restore step budget
        seek_checks(0, 30, 1, 1, 1);
        rst_max = 16'd10;
        do_cmd(1, 0, 1, 1, 1);
        chk(r_er && n_step == 10, "R9 budget error", n_step, 10);
        chk(cur_trk_o == 16'd20 && pos == 20, "R9 track after budget", int'(cur_trk_o), 20);
        rst_max = 16'd100;
        do_cmd(1, 0, 1, 1, 1);
        chk(r_ok && cur_trk_o == '0, "R9 restore after error", int'(cur_trk_o), 0);

        // R10 pulsed restore
        seek_checks(0, 25, 1, 1, 1);
        do_cmd(2, 0, 3, 1, 1);
        chk(r_ok && n_rtz == 1 && n_step == 0, "R10 single pulse", n_step, 0);
        chk(bad_rw == 0, "R10 pulse width", bad_rw, 0);
        chk(cur_trk_o == '0, "R10 track zero", int'(cur_trk_o), 0);
        seek_checks(0, 7, 1, 1, 1);
        rtz_fail = 1'b1;
        do_cmd(2, 0, 2, 1, 1);
        rtz_fail = 1'b0;
        chk(r_ok && n_rtz == 1 && n_step == 7, "R10 fallback steps", n_step, 7);
        chk(cur_trk_o == '0 && pos == 0, "R10 fallback track", int'(cur_trk_o), 0);

        // R11 threshold moves while idle
        seek_checks(0, 15, 1, 1, 1);
        pcomp_trk = 16'd15; rwc_trk = 16'd16;
        repeat (3) @(negedge clk);
        chk(pcen_o && !rwc_o, "R11 equal threshold", int'({pcen_o, rwc_o}), 2);
        pcomp_trk = 16'd16; rwc_trk = 16'd0;
        repeat (3) @(negedge clk);
        chk(!pcen_o && rwc_o, "R11 threshold above", int'({pcen_o, rwc_o}), 1);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule